// File: doc/BRIEF.md
# Latency-Aware Streaming Sink Buffer

This block is a synchronous FIFO for the receiving end of a streaming link. On that link the sink's ready output acts ahead of time. A ready level driven in one cycle opens a capture slot a fixed number of cycles later (`READY_LAT`). After ready drops, the source may still push a bounded number of extra beats (`ALLOWANCE`). The buffer captures those beats, keeps them in arrival order and hands them downstream on an ordinary valid/ready port with no latency.

Input ready is a registered almost-full indication. It is deasserted early enough that every beat the source may still legally send after ready falls has a free slot. The block follows the ready level it drove on earlier cycles, and it keeps a credit count of allowance beats. With these it knows whether the current cycle permits a beat. A beat that arrives outside that window raises a sticky error flag. The beat is still kept while there is room.

When both latency and allowance are zero, the input side becomes a plain handshake. A beat is taken only when valid and ready are high together. A negative `ALLOWANCE` selects an allowance equal to `READY_LAT`. `DEPTH` must be at least `READY_LAT + allowance + 2`.

Top module: `lat_sink_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the FIFO is emptied and the delay line and error flag are cleared. In the first cycle after reset `out_valid`, `protocol_error` and `in_ready` are all 0.
- R2: When `in_ready` is high in cycle n, cycle n+`READY_LAT` is a permitted cycle. A beat presented with `in_valid` high in a permitted cycle is stored.
- R3: With `READY_LAT`=0 and allowance 0, a beat is stored only in a cycle where `in_valid` and `in_ready` are both high. A valid beat while `in_ready` is low is not stored and does not raise `protocol_error`.
- R4: Once the permitted cycles stop, up to allowance further valid beats are stored without an error. A negative `ALLOWANCE` means allowance = `READY_LAT`.
- R5: `in_ready` is registered. It is 1 in the next cycle exactly when the occupancy after the current cycle, plus `READY_LAT` + allowance + 1, is at most `DEPTH`. A source that keeps to the contract therefore never meets a full buffer.
- R6: In the non-handshake modes, a valid beat in a cycle that is neither permitted nor covered by remaining allowance sets `protocol_error` from the next cycle until reset. The beat is still stored if the buffer is not full.
- R7: Stored beats leave on `out_data` in arrival order, each exactly once. `out_valid` is high whenever the buffer holds a beat. A beat leaves in a cycle with `out_valid` and `out_ready` both high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_W | Beat data from the source |
| in_valid | input | 1 | Source presents a beat |
| in_ready | output | 1 | Early almost-full based ready to the source |
| out_data | output | DATA_W | Oldest stored beat |
| out_valid | output | 1 | Buffer is not empty |
| out_ready | input | 1 | Downstream takes the beat |
| protocol_error | output | 1 | Sticky flag for a beat outside the permitted window |

## Verification
The bench runs five latency/allowance pairs side by side, including the plain handshake and a defaulted allowance. Each source sends as fast as its window allows while the output stalls at random, then floods a stalled buffer to force late beats. If the delay line is one stage off, permitted cycles shift and beats in the allowance tail are wrongly flagged. If the almost-full threshold is miscounted, `in_ready` differs from the model in the very cycle the occupancy crosses the limit, or beats are dropped at the full boundary. If the credit reload or decrement is wrong, the error flag appears too early or never. If the handshake mode stores unacknowledged beats, duplicates show up on the output.

// File: rtl/lat_sink_fifo.sv
module lat_sink_fifo #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 8,
  parameter int READY_LAT = 1,
  parameter int ALLOWANCE = -1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              protocol_error
);
  localparam int ALLOW  = (ALLOWANCE < 0) ? READY_LAT : ALLOWANCE;
  localparam bit PLAIN  = (READY_LAT == 0) && (ALLOW == 0);
  localparam int MARGIN = READY_LAT + ALLOW + 1;
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int KW     = (ALLOW > 0) ? $clog2(ALLOW + 1) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt, cnt_nx;
  logic [KW-1:0]     credit;
  logic              ready_cyc, window, push, pop, full;

  assign full      = (cnt == CW'(DEPTH));
  assign window    = ready_cyc | (credit != '0);
  assign push      = PLAIN ? (in_valid & in_ready) : (in_valid & ~full);
  assign out_valid = (cnt != '0);
  assign pop       = out_valid & out_ready;
  assign out_data  = mem[rd_ptr];
  assign cnt_nx    = cnt + CW'(push) - CW'(pop);

  generate
    if (READY_LAT > 0) begin : g_dly
      logic [READY_LAT-1:0] dq;
      always_ff @(posedge clk) begin
        if (!rst_n) dq <= '0;
        else        dq <= (dq << 1) | READY_LAT'(in_ready);
      end
      assign ready_cyc = dq[READY_LAT-1];
    end else begin : g_nodly
      assign ready_cyc = in_ready;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        credit <= '0;
    else if (ready_cyc)                credit <= KW'(ALLOW);
    else if (in_valid && credit != '0) credit <= credit - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready       <= 1'b0;
      protocol_error <= 1'b0;
    end else begin
      in_ready <= (32'(cnt_nx) + MARGIN <= DEPTH);
      if (!PLAIN && in_valid && !window) protocol_error <= 1'b1;
    end
  end
endmodule

// File: rtl/lat_sink_fifo_chk.sv
module lat_sink_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              protocol_error,
  input logic [CW-1:0]     cnt
);
  p_ready_low_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !in_ready);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_sticky_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    protocol_error |=> protocol_error);

  p_err_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protocol_error) |-> $past(in_valid));
endmodule

bind lat_sink_fifo lat_sink_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CW($clog2(DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .protocol_error(protocol_error), .cnt(cnt)
);

// File: tb/lat_sink_fifo_tb_top.sv
module lat_sink_fifo_tb_case #(
  parameter int LAT   = 1,
  parameter int ALW   = -1,
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   checks,
  output int   fails
);
  localparam int AE = (ALW < 0) ? LAT : ALW;
  localparam bit HS = (LAT == 0) && (AE == 0);

  logic [7:0] in_data, out_data;
  logic in_valid, in_ready, out_valid, out_ready, perr;
  logic [7:0] q[$];

  lat_sink_fifo #(.DATA_W(8), .DEPTH(DEPTH), .READY_LAT(LAT), .ALLOWANCE(ALW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .protocol_error(perr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (L=%0d A=%0d) act=%0d exp=%0d", tag, LAT, AE, act, exp);
    end
  endtask

  initial begin
    int credit;
    bit exp_rdy, exp_err, rc, win, v, o, push, pop, prev_hold;
    bit rh[16];
    logic [7:0] seq, prev_data;
    done = 0; checks = 0; fails = 0;
    in_valid = 0; in_data = 0; out_ready = 0;
    credit = 0; exp_rdy = 0; exp_err = 0; prev_hold = 0; prev_data = 0; seq = 0;
    for (int k = 0; k < 16; k++) rh[k] = 0;
    @(posedge rst_n);
    for (int c = 0; c < 700; c++) begin
      @(negedge clk);
      if (c == 0) begin
        chk(!in_ready, "R1 in_ready after reset", in_ready, 0);
        chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
        chk(!perr, "R1 protocol_error after reset", perr, 0);
      end
      chk(in_ready == exp_rdy, "R5 in_ready", in_ready, exp_rdy);
      chk(out_valid == (q.size() != 0), "R7 out_valid", out_valid, q.size() != 0);
      if (q.size() != 0) chk(out_data == q[0], "R2/R7 out_data", out_data, q[0]);
      if (prev_hold) chk(out_data == prev_data, "R8 held data", out_data, prev_data);
      chk(perr == exp_err, "R4/R6 protocol_error", perr, exp_err);

      rc  = (LAT == 0) ? in_ready : rh[LAT-1];
      win = rc || (credit > 0);
      if (c < 400) begin
        v = HS ? ($urandom_range(3) != 0) : (win && ($urandom_range(9) != 0));
        o = ($urandom_range(1) == 1);
      end else if (c < 430) begin
        v = 1; o = 0;
      end else begin
        v = 0; o = 1;
      end
      pop  = (q.size() != 0) && o;
      push = HS ? (v && in_ready) : (v && (q.size() < DEPTH));
      if (pop) void'(q.pop_front());
      if (push) q.push_back(seq);
      if (!HS && v && !win) exp_err = 1;
      if (rc) credit = AE;
      else if (v && credit > 0) credit--;
      exp_rdy = (q.size() + LAT + AE + 1 <= DEPTH);
      for (int k = 15; k > 0; k--) rh[k] = rh[k-1];
      rh[0] = in_ready;
      prev_hold = out_valid && !o;
      prev_data = out_data;
      in_valid  = v;
      in_data   = seq;
      out_ready = o;
      if (HS ? push : v) seq++;
    end
    @(negedge clk);
    if (HS) chk(perr == 0, "R3 unacknowledged beats raise no error", perr, 0);
    else    chk(perr == 1, "R6 late beat flagged", perr, 1);
    chk(!out_valid && q.size() == 0, "R7 fully drained", out_valid, 0);
    done = 1;
  end
endmodule

module lat_sink_fifo_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d[5];
  int ck[5], fl[5];
  bit finished = 0;

  always #5 clk = ~clk;

  lat_sink_fifo_tb_case #(.LAT(0), .ALW(0),  .DEPTH(4)) c0 (.clk(clk), .rst_n(rst_n), .done(d[0]), .checks(ck[0]), .fails(fl[0]));
  lat_sink_fifo_tb_case #(.LAT(0), .ALW(1),  .DEPTH(4)) c1 (.clk(clk), .rst_n(rst_n), .done(d[1]), .checks(ck[1]), .fails(fl[1]));
  lat_sink_fifo_tb_case #(.LAT(1), .ALW(2),  .DEPTH(8)) c2 (.clk(clk), .rst_n(rst_n), .done(d[2]), .checks(ck[2]), .fails(fl[2]));
  lat_sink_fifo_tb_case #(.LAT(2), .ALW(-1), .DEPTH(8)) c3 (.clk(clk), .rst_n(rst_n), .done(d[3]), .checks(ck[3]), .fails(fl[3]));
  lat_sink_fifo_tb_case #(.LAT(3), .ALW(0),  .DEPTH(6)) c4 (.clk(clk), .rst_n(rst_n), .done(d[4]), .checks(ck[4]), .fails(fl[4]));

  task automatic report(input int extra_bad);
    int tot, bad;
    tot = extra_bad; bad = extra_bad;
    for (int i = 0; i < 5; i++) begin
      tot += ck[i];
      bad += fl[i];
    end
    $display("test done: total=%0d bad=%0d", tot, bad);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
  end

  initial begin
    wait (d[0] && d[1] && d[2] && d[3] && d[4]);
    if (!finished) begin
      finished = 1;
      report(0);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("FAIL R7 watchdog expired act=0 exp=1");
      report(1);
      $finish;
    end
  end
endmodule